// File: doc/BRIEF.md
# USB Controller Interrupt Aggregation Wrapper

This block sits between a USB dual-role controller core and a host CPU. It gathers event pulses from the core into two register groups, one for endpoint events and one for core-level events, and drives a single interrupt line toward the CPU. Each group holds a raw source word, a mask word, write-one-to-set and write-one-to-clear ports for both, and a read-only view of the source gated by the mask. Software can force any valid source bit through its set port. This lets it inject an interrupt, for example to start polling after a mode change.

The interrupt line gives one pulse when masked work exists. It then stays quiet until software writes the end-of-interrupt register. After that write the block looks again at the masked sources, so events that are still pending raise a new pulse. A change of the VBUS-drive input on either edge is synchronised and recorded as a core event. The level is also readable in a status register. A control register bit clears both groups in one step. All registers sit on a simple 32-bit bus with byte offsets, single-cycle writes and combinational reads.

Top module: `usb_irq_wrap`

## Requirements
- R1: Offset 0x00 reads the non-zero constant REV_ID. Offsets 0x10 and 0x5C, the set and clear ports (0x24, 0x28, 0x30, 0x34, 0x44, 0x48, 0x50, 0x54), the end-of-interrupt port 0x60 and unmapped offsets all read 0. Writes to 0x10 and 0x5C change nothing.
- R2: In the endpoint words (source 0x20, mask 0x2C, masked 0x38), bits 15:0 are transmit endpoints 0..15 and bits 31:17 are receive endpoints 1..15. Bit 16 always reads 0 and ignores writes and events.
- R3: In the core words (source 0x40, mask 0x4C, masked 0x58), only bits 24:16 exist. Input core_evt_i[k] maps to bit 16+k for k = 0..7, and bit 24 is the VBUS-drive change event. All other bits read 0.
- R4: Writing the set port (0x24 endpoint, 0x44 core) sets every source bit written as 1. Bits written as 0 keep their value.
- R5: Writing the clear port (0x28 endpoint, 0x48 core) clears every source bit written as 1. Bits written as 0 keep their value.
- R6: Mask set ports (0x30, 0x50) and mask clear ports (0x34, 0x54) set or clear mask bits written as 1. The mask reads back at 0x2C and 0x4C.
- R7: The masked view (0x38, 0x58) always reads source AND mask.
- R8: An event pulse on ep_evt_i or core_evt_i sets its source bit at the next clock edge. If a clear write hits the same bit in the same cycle, the event wins.
- R9: irq_o is high for exactly one cycle when any masked bit of either group is set and no end-of-interrupt is outstanding. It then stays low until a write of any value to 0x60. From the cycle after that write it follows the masked state again.
- R10: Writing 1 to bit 0 of control (0x04) clears all source bits, all mask bits and any outstanding end-of-interrupt at that edge. Control bit 0 reads 1 in the following cycle only, then reads 0.
- R11: Status (0x08) bit 0 shows vbus_drv_i after a two-flop synchroniser, so it is visible two clock edges after the input changes. The other bits read 0.
- R12: Each rising or falling change of vbus_drv_i sets core source bit 24 at the third clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ep_evt_i | input | 32 | Endpoint event pulses, same layout as endpoint source |
| core_evt_i | input | 8 | Core event pulses for core source bits 23:16 |
| vbus_drv_i | input | 1 | Asynchronous VBUS-drive level from the core |
| irq_o | output | 1 | Interrupt pulse to the CPU |

## Verification
The embedded properties check on every cycle that an interrupt pulse never lasts more than one cycle without an end-of-interrupt, that an event always lands in its source bit even against a clear, that a clear or a mask-set write takes full effect, that soft reset leaves both groups empty, and that a synchronised VBUS edge always records bit 24. Only the bench scenarios show the re-raise of the line after an end-of-interrupt while work is pending, the exact latency of the synchroniser and of the edge event, the read-back layout with its unused bits, and the agreement of long random sequences of set, clear, mask and event traffic with a reference model.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned CORE_EVT_W = 8;
  localparam int unsigned CORE_LSB = 16;
  localparam int unsigned VBUS_BIT = CORE_LSB + CORE_EVT_W;

  localparam logic [AW-1:0] OFF_REV  = 8'h00;
  localparam logic [AW-1:0] OFF_CTRL = 8'h04;
  localparam logic [AW-1:0] OFF_STAT = 8'h08;
  localparam logic [AW-1:0] OFF_EOI  = 8'h60;
  localparam logic [AW-1:0] EP_BASE  = 8'h20;
  localparam logic [AW-1:0] CORE_BASE = 8'h40;

  // offsets inside a group
  localparam logic [AW-1:0] G_SRC   = 8'h00;
  localparam logic [AW-1:0] G_SET   = 8'h04;
  localparam logic [AW-1:0] G_CLR   = 8'h08;
  localparam logic [AW-1:0] G_MASK  = 8'h0C;
  localparam logic [AW-1:0] G_MSET  = 8'h10;
  localparam logic [AW-1:0] G_MCLR  = 8'h14;
  localparam logic [AW-1:0] G_MSKD  = 8'h18;

  localparam logic [DW-1:0] EP_VALID   = 32'hFFFE_FFFF;
  localparam logic [DW-1:0] CORE_VALID = ((32'h1 << (CORE_EVT_W + 1)) - 32'h1) << CORE_LSB;

  typedef struct packed {
    logic set;
    logic clr;
    logic mset;
    logic mclr;
  } grp_wr_t;
endpackage

// File: rtl/usb_irq_vbus_sync.sv
module usb_irq_vbus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vbus_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], vbus_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign edge_o  = level_o ^ prev_q;
endmodule

// File: rtl/usb_irq_group.sv
module usb_irq_group
  import usb_irq_pkg::*;
#(
  parameter logic [DW-1:0] VALID = EP_VALID
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  grp_wr_t       wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] evt_i,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] masked_o
);
  logic [DW-1:0] src_q, src_d, mask_q, mask_d;

  always_comb begin
    src_d = src_q;
    if (wr_i.set) src_d = src_d | wdata_i;
    if (wr_i.clr) src_d = src_d & ~wdata_i;
    src_d = (src_d | evt_i) & VALID;  // event beats a same-cycle clear
    if (srst_i) src_d = '0;
    mask_d = mask_q;
    if (wr_i.mset) mask_d = mask_d | wdata_i;
    if (wr_i.mclr) mask_d = mask_d & ~wdata_i;
    mask_d = mask_d & VALID;
    if (srst_i) mask_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      src_q  <= src_d;
      mask_q <= mask_d;
    end
  end

  assign src_o    = src_q;
  assign mask_o   = mask_q;
  assign masked_o = src_q & mask_q;

  p_evt_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && |(evt_i & VALID)) |=> ((src_q & $past(evt_i & VALID)) == $past(evt_i & VALID)));

  p_clr_takes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i.clr && !wr_i.set && evt_i == '0) |=> ((src_q & $past(wdata_i)) == '0));

  p_mset_takes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i.mset && !wr_i.mclr && !srst_i) |=> ((mask_q & $past(wdata_i & VALID)) == $past(wdata_i & VALID)));
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usb_irq_pkg::*;
#(
  parameter logic [DW-1:0] REV_ID = 32'h0002_0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] ep_evt_i,
  input  logic [CORE_EVT_W-1:0] core_evt_i,
  input  logic          vbus_drv_i,
  output logic          irq_o
);
  localparam int unsigned NGRP = 2;

  logic vbus_lvl, vbus_edge;
  logic srst, eoi_wr, ctrl_q, hold_q;
  grp_wr_t       gwr    [NGRP];
  logic [DW-1:0] gevt   [NGRP];
  logic [DW-1:0] gsrc   [NGRP];
  logic [DW-1:0] gmask  [NGRP];
  logic [DW-1:0] gmskd  [NGRP];

  usb_irq_vbus_sync #(.STAGES(2)) u_vbus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vbus_i (vbus_drv_i),
    .level_o(vbus_lvl),
    .edge_o (vbus_edge)
  );

  assign gevt[0] = ep_evt_i;
  assign gevt[1] = {{(DW-VBUS_BIT-1){1'b0}}, vbus_edge, core_evt_i, {CORE_LSB{1'b0}}};

  assign srst   = wr_i && (addr_i == OFF_CTRL) && wdata_i[0];
  assign eoi_wr = wr_i && (addr_i == OFF_EOI);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [AW-1:0] BASE = (g == 0) ? EP_BASE : CORE_BASE;
    localparam logic [DW-1:0] VLD  = (g == 0) ? EP_VALID : CORE_VALID;
    assign gwr[g].set  = wr_i && (addr_i == BASE + G_SET);
    assign gwr[g].clr  = wr_i && (addr_i == BASE + G_CLR);
    assign gwr[g].mset = wr_i && (addr_i == BASE + G_MSET);
    assign gwr[g].mclr = wr_i && (addr_i == BASE + G_MCLR);

    usb_irq_group #(.VALID(VLD)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .srst_i  (srst),
      .wr_i    (gwr[g]),
      .wdata_i (wdata_i),
      .evt_i   (gevt[g]),
      .src_o   (gsrc[g]),
      .mask_o  (gmask[g]),
      .masked_o(gmskd[g])
    );
  end

  assign irq_o = ((|gmskd[0]) || (|gmskd[1])) && !hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      ctrl_q <= srst;
      if (srst || eoi_wr) hold_q <= 1'b0;
      else if (irq_o)     hold_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_REV:               rdata_o = REV_ID;
      OFF_CTRL:              rdata_o = {{(DW-1){1'b0}}, ctrl_q};
      OFF_STAT:              rdata_o = {{(DW-1){1'b0}}, vbus_lvl};
      EP_BASE + G_SRC:       rdata_o = gsrc[0];
      EP_BASE + G_MASK:      rdata_o = gmask[0];
      EP_BASE + G_MSKD:      rdata_o = gmskd[0];
      CORE_BASE + G_SRC:     rdata_o = gsrc[1];
      CORE_BASE + G_MASK:    rdata_o = gmask[1];
      CORE_BASE + G_MSKD:    rdata_o = gmskd[1];
      default:               rdata_o = '0;
    endcase
  end

  p_irq_one_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !eoi_wr && !srst) |=> !irq_o);

  p_hold_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && hold_q && !eoi_wr && !srst) |=> !irq_o);

  p_srst_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (gsrc[0] == '0 && gsrc[1] == '0 && gmask[0] == '0 && gmask[1] == '0 && !irq_o));

  p_vbus_event_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbus_edge && !srst) |=> gsrc[1][VBUS_BIT]);
endmodule

// File: tb/usb_irq_wrap_tb_top.sv
module usb_irq_wrap_tb_top;
  localparam logic [31:0] REV = 32'h0002_0100;
  localparam logic [31:0] EPV = 32'hFFFE_FFFF;
  localparam logic [31:0] COV = 32'h01FF_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, vbus_drv_i = 1'b0, irq_o;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, ep_evt_i = '0;
  logic [7:0] core_evt_i = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_src [2];
  logic [31:0] m_mask[2];

  always #4 clk_i = ~clk_i;

  usb_irq_wrap #(.REV_ID(REV)) dut_i (.*);

  function automatic logic [31:0] vld(int g);
    return (g == 0) ? EPV : COV;
  endfunction
  function automatic logic [7:0] base(int g);
    return (g == 0) ? 8'h20 : 8'h40;
  endfunction
  function automatic logic [31:0] exp_mskd(int g);
    return m_src[g] & m_mask[g];
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic chk_grp(int g, string req);
    logic [31:0] v;
    rd(base(g) + 8'h00, v); chk(req, v, m_src[g]);
    rd(base(g) + 8'h0C, v); chk(req, v, m_mask[g]);
    rd(base(g) + 8'h18, v); chk({req, " R7"}, v, exp_mskd(g));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hang exp finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int g = 0; g < 2; g++) begin m_src[g] = '0; m_mask[g] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    chk("reset irq", {31'b0, irq_o}, 0);
    chk_grp(0, "reset R2");
    chk_grp(1, "reset R3");

    // R1 map
    rd(8'h00, v); chk("R1 rev", v, REV);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h5C, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R1 rsv10", v, 0);
    rd(8'h5C, v); chk("R1 rsv5c", v, 0);
    chk_grp(0, "R1 no side effect");
    wr(8'h44, 32'h0080_0000); m_src[1] = 32'h0080_0000;
    rd(8'h44, v); chk("R1 set port reads 0", v, 0);
    rd(8'h60, v); chk("R1 eoi reads 0", v, 0);

    // R10 soft reset
    wr(8'h30, 32'h0000_00FF);
    wr(8'h04, 32'h1);
    m_src[1] = '0; m_mask[0] = '0;
    rd(8'h04, v); chk("R10 ctrl one cycle", v, 1);
    chk_grp(0, "R10 ep cleared");
    chk_grp(1, "R10 core cleared");
    @(negedge clk_i);
    rd(8'h04, v); chk("R10 ctrl self clear", v, 0);

    // R2 / R3 unused bits via set port
    wr(8'h24, 32'hFFFF_FFFF); m_src[0] = EPV;
    rd(8'h20, v); chk("R2 bit16 zero", v, 32'hFFFE_FFFF);
    wr(8'h44, 32'hFFFF_FFFF); m_src[1] = COV;
    rd(8'h40, v); chk("R3 core field", v, 32'h01FF_0000);
    // R5 clear with zeros is no-op, then clear bits
    wr(8'h28, 32'h0); chk_grp(0, "R5 zero no effect");
    wr(8'h28, 32'h8000_0001); m_src[0] &= ~32'h8000_0001; chk_grp(0, "R5 clear");
    wr(8'h48, 32'hFFFF_FFFF); m_src[1] = '0;
    // R3 event mapping
    @(negedge clk_i); core_evt_i = 8'h81;
    @(negedge clk_i); core_evt_i = '0;
    m_src[1] = 32'h0081_0000;
    chk_grp(1, "R3 evt map");

    // R8 event vs clear same cycle
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 8'h28; wdata_i = 32'h0003_0006; ep_evt_i = 32'h0001_0004;
    @(negedge clk_i);
    wr_i = 1'b0; ep_evt_i = '0;
    m_src[0] = (m_src[0] & ~32'h0003_0006) | (32'h0001_0004 & EPV);
    chk_grp(0, "R8 evt wins");

    // R11 / R12 vbus
    @(negedge clk_i); vbus_drv_i = 1'b1;
    @(negedge clk_i);
    rd(8'h08, v); chk("R11 stat one edge", v, 0);
    @(negedge clk_i);
    rd(8'h08, v); chk("R11 stat two edges", v, 1);
    rd(8'h40, v); chk("R12 not yet", v[24], 0);
    @(negedge clk_i);
    rd(8'h40, v); chk("R12 rise event", v[24], 1);
    m_src[1][24] = 1'b1;
    wr(8'h48, 32'h0100_0000); m_src[1][24] = 1'b0;
    vbus_drv_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rd(8'h40, v); chk("R12 fall event", v[24], 1);
    m_src[1][24] = 1'b1;

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int g, op;
      logic [31:0] d, e;
      g = $urandom_range(0, 1);
      op = $urandom_range(0, 5);
      d = $urandom;
      e = $urandom;
      case (op)
        0: begin wr(base(g) + 8'h04, d); m_src[g] = (m_src[g] | d) & vld(g); end
        1: begin wr(base(g) + 8'h08, d); m_src[g] = m_src[g] & ~d; end
        2: begin wr(base(g) + 8'h10, d); m_mask[g] = (m_mask[g] | d) & vld(g); end
        3: begin wr(base(g) + 8'h14, d); m_mask[g] = m_mask[g] & ~d; end
        4: begin
          @(negedge clk_i); ep_evt_i = d; core_evt_i = e[7:0];
          @(negedge clk_i); ep_evt_i = '0; core_evt_i = '0;
          m_src[0] = (m_src[0] | d) & EPV;
          m_src[1] = m_src[1] | {7'b0, 1'b0, e[7:0], 16'b0};
        end
        default: begin
          logic [31:0] ew;
          ew = (g == 0) ? (e & EPV) : {8'b0, e[7:0], 16'b0};
          @(negedge clk_i);
          wr_i = 1'b1; addr_i = base(g) + 8'h08; wdata_i = d;
          if (g == 0) ep_evt_i = e; else core_evt_i = e[7:0];
          @(negedge clk_i);
          wr_i = 1'b0; ep_evt_i = '0; core_evt_i = '0;
          m_src[g] = (m_src[g] & ~d) | ew;
        end
      endcase
      chk_grp(g, (op < 2) ? "R4 R5 rand" : (op < 4) ? "R6 rand" : "R8 rand");
    end

    // R9 irq pulse and end-of-interrupt
    wr(8'h04, 32'h1);
    m_src[0] = '0; m_src[1] = '0; m_mask[0] = '0; m_mask[1] = '0;
    @(negedge clk_i);
    chk("R9 idle", {31'b0, irq_o}, 0);
    wr(8'h30, 32'h0000_0008);
    chk("R9 masked empty", {31'b0, irq_o}, 0);
    wr(8'h24, 32'h0000_0008);
    chk("R9 fires", {31'b0, irq_o}, 1);
    @(negedge clk_i);
    chk("R9 one cycle", {31'b0, irq_o}, 0);
    repeat (3) @(negedge clk_i);
    chk("R9 quiet", {31'b0, irq_o}, 0);
    wr(8'h60, 32'h0);
    chk("R9 refire after eoi", {31'b0, irq_o}, 1);
    @(negedge clk_i);
    wr(8'h28, 32'h0000_0008);
    wr(8'h60, 32'h0);
    chk("R9 no refire empty", {31'b0, irq_o}, 0);
    wr(8'h50, 32'h0000_0000);
    @(negedge clk_i); core_evt_i = 8'h02;
    @(negedge clk_i); core_evt_i = '0;
    chk("R9 unmasked core quiet", {31'b0, irq_o}, 0);
    wr(8'h50, 32'h0002_0000);
    chk("R9 core masked fires", {31'b0, irq_o}, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule